// File: doc/BRIEF.md
# Multiprocessor UART with address filtering

This block is an asynchronous serial port that works with frames of eight or nine data bits. A host reaches it through four byte-wide register addresses. A single data address serves both directions: a write starts a transmission and a read returns the last byte received. The transmitter sends a low start bit, the data bits LSB first, an optional ninth bit and a high stop bit. Each bit lasts sixteen cycles of the oversampling tick `tick_i`, which comes from a baud generator outside the block.

The receiver samples the line once per tick. It checks the start bit at mid-bit and takes every bit as the majority of three samples around the bit centre. A finished frame goes into a holding register, so the next frame can arrive while the host has not yet read the previous one. The block reports overrun and stop-bit errors in sticky status bits. In multiprocessor mode the receiver uses the ninth bit to tell address frames from data frames. It drops data frames, and it accepts an address frame only when the bits selected by a mask register equal the same bits of a station address register. The transmit-complete and receive-complete flags stay set until the host clears them. The interrupt request is the OR of those two flags.

Register map: address 0 is data, address 1 is control/status, address 2 is the station address and address 3 is the address mask. Control/status bits: [0] rx_done, [1] tx_done, [2] overrun, [3] frame_err, [4] rx_bit8 (read only), [5] tx_bit8, [6] nine_en, [7] mp_en.

Top module: `mp_uart`

## Requirements
- R1: After reset, txd_o is 1, irq_o is 0 and the control/status register reads 0x00.
- R2: A write to address 0 while idle sends start 0, eight data bits LSB first, then tx_bit8 if nine_en=1, then stop 1. Each bit lasts 16 ticks. A data write made while a frame is being sent is ignored.
- R3: A received frame that is accepted loads the holding register and sets rx_done (status bit 0). A read of address 0 returns the byte. Status bit 4 holds the received ninth bit in nine-bit mode and reads 0 otherwise.
- R4: tx_done (status bit 1) is set at the end of the stop bit of each transmitted frame.
- R5: rx_done, tx_done, overrun and frame_err are sticky. Writing 0 to a bit in address 1 clears it and writing 1 leaves it unchanged. irq_o is 1 exactly when rx_done or tx_done is 1.
- R6: overrun (status bit 2) is set when a frame is accepted while the previous byte has not been read from address 0.
- R7: A stop bit sampled as 0 sets frame_err (status bit 3). The byte is still loaded and rx_done is still set.
- R8: When mp_en=1 and nine_en=1, a frame with ninth bit 1 is accepted only when ((byte XOR station) AND mask) is 0. With mask 0x00, every address frame is accepted.
- R9: When mp_en=1, a frame with ninth bit 0 leaves the holding register and every status flag unchanged.
- R10: A low pulse on the line that is high again by the start-bit centre starts no reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Oversampling tick, 16 per bit time |
| addr_i | input | 2 | Register address |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe (marks the data as read at address 0) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data of the addressed register (combinational) |
| rxd_i | input | 1 | Serial receive line |
| txd_o | output | 1 | Serial transmit line |
| irq_o | output | 1 | Interrupt request |

## Verification
A wrong internal state in this block reaches the ports within one frame. A bad bit counter or tick counter gives a wrong serial stream or a wrong byte after a loopback. A stuck unread marker shows as a wrong overrun bit on the next accepted frame. A broken address comparator is found when every address from 0 to 63 is sent against a partial mask and each accept or reject is compared with the arithmetic prediction. Stuck flags appear in irq_o and in the status read that follows each frame.

// File: rtl/mp_uart_pkg.sv
package mp_uart_pkg;
  typedef enum logic [1:0] {
    ADDR_DATA = 2'd0,
    ADDR_STAT = 2'd1,
    ADDR_STN  = 2'd2,
    ADDR_MASK = 2'd3
  } reg_addr_e;

  localparam int unsigned ST_RX_DONE = 0;
  localparam int unsigned ST_TX_DONE = 1;
  localparam int unsigned ST_OVR     = 2;
  localparam int unsigned ST_FERR    = 3;
  localparam int unsigned ST_RB8     = 4;
  localparam int unsigned ST_TB8     = 5;
  localparam int unsigned ST_NINE    = 6;
  localparam int unsigned ST_MP      = 7;
endpackage

// File: rtl/mp_uart_tx.sv
module mp_uart_tx #(
  parameter int unsigned DW  = 8,
  parameter int unsigned OVS = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          start_i,
  input  logic [DW-1:0] data_i,
  input  logic          nine_i,
  input  logic          bit8_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          txd_o
);
  localparam int unsigned CW = $clog2(OVS);
  localparam int unsigned FW = DW + 3;
  localparam int unsigned BW = $clog2(FW + 1);

  logic [FW-1:0] sh_q;
  logic [CW-1:0] cnt_q;
  logic [BW-1:0] idx_q;
  logic          nine_q;
  logic [BW-1:0] last_idx;

  assign last_idx = nine_q ? BW'(FW - 1) : BW'(FW - 2);
  assign txd_o    = busy_o ? sh_q[0] : 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '1;
      cnt_q  <= '0;
      idx_q  <= '0;
      nine_q <= 1'b0;
      busy_o <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (!busy_o && start_i) begin
        sh_q   <= {1'b1, (nine_i ? bit8_i : 1'b1), data_i, 1'b0};
        nine_q <= nine_i;
        cnt_q  <= '0;
        idx_q  <= '0;
        busy_o <= 1'b1;
      end else if (busy_o && tick_i) begin
        if (cnt_q == CW'(OVS - 1)) begin
          cnt_q <= '0;
          sh_q  <= {1'b1, sh_q[FW-1:1]};
          if (idx_q == last_idx) begin
            busy_o <= 1'b0;
            done_o <= 1'b1;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  a_r2_start_bit_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (txd_o == 1'b0));
  a_r4_done_ends_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  a_r2_busy_holds_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !tick_i) |=> $stable(txd_o));
endmodule

// File: rtl/mp_uart_rx.sv
module mp_uart_rx #(
  parameter int unsigned DW  = 8,
  parameter int unsigned OVS = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          rxd_i,
  input  logic          nine_i,
  output logic          done_o,
  output logic [DW-1:0] data_o,
  output logic          bit8_o,
  output logic          stop_o
);
  localparam int unsigned CW  = $clog2(OVS);
  localparam int unsigned BW  = $clog2(DW + 3);
  localparam int unsigned MID = OVS / 2 - 1;

  logic [1:0]    sync_q;
  logic          rxs;
  logic          active_q;
  logic [CW-1:0] cnt_q;
  logic [BW-1:0] idx_q;
  logic          s0_q, s1_q;
  logic [DW:0]   shr_q;
  logic          maj;
  logic [BW-1:0] last_idx;

  assign rxs      = sync_q[1];
  assign maj      = (s0_q & s1_q) | (s0_q & rxs) | (s1_q & rxs);
  assign last_idx = nine_i ? BW'(DW + 2) : BW'(DW + 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q   <= 2'b11;
      active_q <= 1'b0;
      cnt_q    <= '0;
      idx_q    <= '0;
      s0_q     <= 1'b1;
      s1_q     <= 1'b1;
      shr_q    <= '0;
      done_o   <= 1'b0;
      data_o   <= '0;
      bit8_o   <= 1'b0;
      stop_o   <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], rxd_i};
      done_o <= 1'b0;
      if (tick_i) begin
        if (!active_q) begin
          if (!rxs) begin
            active_q <= 1'b1;
            cnt_q    <= CW'(1);
            idx_q    <= '0;
            shr_q    <= '0;
          end
        end else begin
          cnt_q <= (cnt_q == CW'(OVS - 1)) ? '0 : cnt_q + 1'b1;
          if (cnt_q == CW'(MID))     s0_q <= rxs;
          if (cnt_q == CW'(MID + 1)) s1_q <= rxs;
          if (cnt_q == CW'(MID + 2)) begin
            if (idx_q == '0) begin
              if (maj) active_q <= 1'b0;
              else     idx_q    <= idx_q + 1'b1;
            end else if (idx_q == last_idx) begin
              active_q <= 1'b0;
              done_o   <= 1'b1;
              data_o   <= shr_q[DW-1:0];
              bit8_o   <= nine_i & shr_q[DW];
              stop_o   <= maj;
            end else begin
              shr_q[idx_q - BW'(1)] <= maj;
              idx_q <= idx_q + 1'b1;
            end
          end
        end
      end
    end
  end

  a_r10_start_needs_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active_q) |-> !$past(rxs));
  a_r3_done_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/mp_uart_addr_match.sv
module mp_uart_addr_match #(
  parameter int unsigned DW = 8
) (
  input  logic [DW-1:0] addr_i,
  input  logic [DW-1:0] station_i,
  input  logic [DW-1:0] mask_i,
  output logic          hit_o
);
  logic [DW-1:0] miss;

  for (genvar g = 0; g < DW; g++) begin : g_bit
    assign miss[g] = mask_i[g] & (addr_i[g] ^ station_i[g]);
  end

  assign hit_o = ~|miss;
endmodule

// File: rtl/mp_uart.sv
module mp_uart
  import mp_uart_pkg::*;
#(
  parameter int unsigned DW  = 8,
  parameter int unsigned OVS = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic [1:0]    addr_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          rxd_i,
  output logic          txd_o,
  output logic          irq_o
);
  logic [DW-1:0] hold_q, stn_q, msk_q;
  logic unread_q, rx_done_q, tx_done_q, ovr_q, ferr_q, rb8_q, tb8_q, nine_q, mp_q;

  logic          wr_stat, wr_data, rd_data;
  logic          tx_busy, tx_fin;
  logic          rx_fin, rx_b8, rx_stop, hit, accept;
  logic [DW-1:0] rx_byte;
  logic [7:0]    status;

  assign wr_stat = wr_i && (addr_i == ADDR_STAT);
  assign wr_data = wr_i && (addr_i == ADDR_DATA);
  assign rd_data = rd_i && (addr_i == ADDR_DATA);

  mp_uart_tx #(.DW(DW), .OVS(OVS)) u_tx (
    .clk_i, .rst_ni, .tick_i,
    .start_i (wr_data),
    .data_i  (wdata_i),
    .nine_i  (nine_q),
    .bit8_i  (tb8_q),
    .busy_o  (tx_busy),
    .done_o  (tx_fin),
    .txd_o
  );

  mp_uart_rx #(.DW(DW), .OVS(OVS)) u_rx (
    .clk_i, .rst_ni, .tick_i, .rxd_i,
    .nine_i (nine_q),
    .done_o (rx_fin),
    .data_o (rx_byte),
    .bit8_o (rx_b8),
    .stop_o (rx_stop)
  );

  mp_uart_addr_match #(.DW(DW)) u_match (
    .addr_i    (rx_byte),
    .station_i (stn_q),
    .mask_i    (msk_q),
    .hit_o     (hit)
  );

  assign accept = rx_fin && (!mp_q || (rx_b8 && hit));
  assign irq_o  = rx_done_q | tx_done_q;
  assign status = {mp_q, nine_q, tb8_q, rb8_q, ferr_q, ovr_q, tx_done_q, rx_done_q};

  always_comb begin
    case (addr_i)
      ADDR_DATA: rdata_o = hold_q;
      ADDR_STAT: rdata_o = DW'(status);
      ADDR_STN:  rdata_o = stn_q;
      default:   rdata_o = msk_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0; stn_q <= '0; msk_q <= '0;
      unread_q <= 1'b0; rx_done_q <= 1'b0; tx_done_q <= 1'b0;
      ovr_q <= 1'b0; ferr_q <= 1'b0; rb8_q <= 1'b0;
      tb8_q <= 1'b0; nine_q <= 1'b0; mp_q <= 1'b0;
    end else begin
      if (wr_stat) begin
        rx_done_q <= rx_done_q & wdata_i[ST_RX_DONE];
        tx_done_q <= tx_done_q & wdata_i[ST_TX_DONE];
        ovr_q     <= ovr_q     & wdata_i[ST_OVR];
        ferr_q    <= ferr_q    & wdata_i[ST_FERR];
        tb8_q     <= wdata_i[ST_TB8];
        nine_q    <= wdata_i[ST_NINE];
        mp_q      <= wdata_i[ST_MP];
      end
      if (wr_i && addr_i == ADDR_STN)  stn_q <= wdata_i;
      if (wr_i && addr_i == ADDR_MASK) msk_q <= wdata_i;
      if (rd_data) unread_q <= 1'b0;
      if (tx_fin) tx_done_q <= 1'b1;
      if (accept) begin
        hold_q    <= rx_byte;
        rb8_q     <= rx_b8;
        rx_done_q <= 1'b1;
        unread_q  <= 1'b1;
        if (unread_q) ovr_q  <= 1'b1;
        if (!rx_stop) ferr_q <= 1'b1;
      end
    end
  end

  a_r5_rx_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_done_q && !wr_stat) |=> rx_done_q);
  a_r5_tx_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_done_q && !wr_stat) |=> tx_done_q);
  a_r6_overrun_needs_unread: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr_q) |-> $past(unread_q));
  a_r9_data_frame_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_fin && mp_q && !rx_b8 && !wr_stat) |=> ($stable(hold_q) && $stable(rx_done_q)));
  a_r8_address_miss_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_fin && mp_q && rx_b8 && !hit) |=> $stable(hold_q));
  a_r2_no_start_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_data && tx_busy) |=> !tx_fin || $past(tx_fin));
endmodule

// File: tb/mp_uart_tb.sv
`timescale 1ns/1ps
module mp_uart_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [1:0] addr = 2'd0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       rxd_drv = 1'b1, loop = 1'b0;
  logic       rxd, txd, irq;
  int         n_chk = 0, n_err = 0;
  bit         done_flag = 1'b0;

  assign rxd = loop ? txd : rxd_drv;

  mp_uart dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .rxd_i(rxd), .txd_o(txd), .irq_o(irq)
  );

  always #4 clk = ~clk;

  initial forever begin
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rreg(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1; #1; d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic hold_bit(input logic v);
    rxd_drv = v;
    repeat (32) @(negedge clk);
  endtask

  task automatic send_rx(input logic [7:0] d, input logic b8, input logic nine, input logic stop);
    @(negedge clk);
    hold_bit(1'b0);
    for (int i = 0; i < 8; i++) hold_bit(d[i]);
    if (nine) hold_bit(b8);
    hold_bit(stop);
    rxd_drv = 1'b1;
    repeat (16) @(negedge clk);
  endtask

  task automatic wait_tx_done();
    logic [7:0] s;
    for (int i = 0; i < 400; i++) begin
      rreg(2'd1, s);
      if (s[1]) break;
    end
  endtask

  task automatic capture_tx(input logic nine, output logic [7:0] d, output logic b8, output logic stop);
    while (txd !== 1'b0) @(negedge clk);
    repeat (16) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      repeat (32) @(negedge clk);
      d[i] = txd;
    end
    b8 = 1'b0;
    if (nine) begin
      repeat (32) @(negedge clk);
      b8 = txd;
    end
    repeat (32) @(negedge clk);
    stop = txd;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done_flag) begin
      n_chk++; n_err++;
      $display("FAIL watchdog (R1..R10 run) actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] s, d, got;
    logic       b8, stp;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 txd in reset", int'(txd), 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    rreg(2'd1, s);
    chk("R1 status after reset", int'(s), 8'h00);
    chk("R1 irq after reset", int'(irq), 0);
    chk("R1 txd idle", int'(txd), 1);

    // R2: nine-bit frame with tx_bit8=1, second write during busy ignored
    wreg(2'd1, 8'h60);
    fork
      capture_tx(1'b1, got, b8, stp);
      begin
        wreg(2'd0, 8'hA5);
        repeat (100) @(negedge clk);
        wreg(2'd0, 8'h3C);
      end
    join
    chk("R2 tx data", int'(got), 8'hA5);
    chk("R2 tx ninth bit", int'(b8), 1);
    chk("R2 tx stop", int'(stp), 1);
    repeat (40) @(negedge clk);
    rreg(2'd1, s);
    chk("R4 tx_done after frame", int'(s[1]), 1);
    chk("R5 irq follows tx_done", int'(irq), 1);
    repeat (400) @(negedge clk);
    chk("R2 busy write ignored, line idle", int'(txd), 1);
    wreg(2'd1, 8'h62);
    rreg(2'd1, s);
    chk("R5 write 1 keeps tx_done", int'(s[1]), 1);
    wreg(2'd1, 8'h60);
    rreg(2'd1, s);
    chk("R5 write 0 clears tx_done", int'(s[1]), 0);
    chk("R5 irq low after clear", int'(irq), 0);

    // R3: loopback sweep of all bytes, eight-bit mode
    wreg(2'd1, 8'h00);
    loop = 1'b1;
    for (int v = 0; v < 256; v++) begin
      wreg(2'd0, 8'(v));
      wait_tx_done();
      rreg(2'd1, s);
      chk("R3 R4 status after loopback", int'(s), 8'h03);
      rreg(2'd0, d);
      chk("R3 loopback byte", int'(d), v);
      wreg(2'd1, 8'h00);
    end

    // R3: ninth bit received
    wreg(2'd1, 8'h60);
    wreg(2'd0, 8'h3C);
    wait_tx_done();
    rreg(2'd1, s);
    chk("R3 rx_bit8 set", int'(s[4]), 1);
    rreg(2'd0, d);
    chk("R3 nine-bit byte", int'(d), 8'h3C);
    loop = 1'b0;

    // R6: overrun
    wreg(2'd1, 8'h00);
    send_rx(8'h11, 1'b0, 1'b0, 1'b1);
    send_rx(8'h22, 1'b0, 1'b0, 1'b1);
    rreg(2'd1, s);
    chk("R6 overrun set", int'(s), 8'h05);
    rreg(2'd0, d);
    chk("R6 holding has newest", int'(d), 8'h22);
    wreg(2'd1, 8'h00);
    send_rx(8'h44, 1'b0, 1'b0, 1'b1);
    rreg(2'd1, s);
    chk("R6 no overrun after read", int'(s), 8'h01);
    rreg(2'd0, d);

    // R7: frame error
    wreg(2'd1, 8'h00);
    send_rx(8'h5A, 1'b0, 1'b0, 1'b0);
    rreg(2'd1, s);
    chk("R7 frame_err and rx_done", int'(s), 8'h09);
    rreg(2'd0, d);
    chk("R7 byte still loaded", int'(d), 8'h5A);
    wreg(2'd1, 8'h00);

    // R8: address sweep, station 0x05, mask 0x0F
    wreg(2'd2, 8'h05);
    wreg(2'd3, 8'h0F);
    wreg(2'd1, 8'hE0);
    loop = 1'b1;
    for (int v = 0; v < 64; v++) begin
      wreg(2'd0, 8'(v));
      wait_tx_done();
      rreg(2'd1, s);
      chk("R8 address accept", int'(s[0]), (((v ^ 5) & 8'h0F) == 0) ? 1 : 0);
      if (s[0]) begin
        rreg(2'd0, d);
        chk("R8 accepted address byte", int'(d), v);
      end
      wreg(2'd1, 8'hE0);
    end

    // R9: data frame dropped
    wreg(2'd1, 8'hC0);
    wreg(2'd0, 8'h05);
    wait_tx_done();
    rreg(2'd1, s);
    chk("R9 data frame no rx_done", int'(s[0]), 0);
    chk("R9 data frame no overrun/ferr", int'(s[3:2]), 0);
    rreg(2'd0, d);
    chk("R9 holding unchanged", int'(d), 8'h35);

    // R8: zero mask matches all
    wreg(2'd3, 8'h00);
    wreg(2'd1, 8'hE0);
    wreg(2'd0, 8'hF0);
    wait_tx_done();
    rreg(2'd1, s);
    chk("R8 zero mask accepts", int'(s[0]), 1);
    rreg(2'd0, d);
    chk("R8 zero mask byte", int'(d), 8'hF0);
    loop = 1'b0;

    // R10: short glitch is no start bit
    wreg(2'd1, 8'h00);
    @(negedge clk);
    rxd_drv = 1'b0;
    repeat (4) @(negedge clk);
    rxd_drv = 1'b1;
    repeat (600) @(negedge clk);
    rreg(2'd1, s);
    chk("R10 glitch ignored", int'(s[0]), 0);
    send_rx(8'hC3, 1'b0, 1'b0, 1'b1);
    rreg(2'd0, d);
    chk("R10 receiver still aligned", int'(d), 8'hC3);

    done_flag = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule